// File: doc/BRIEF.md
# External SRAM program loader

This block lets a host controller place a program image into a byte-wide external SRAM with a 19-bit address. It does this while the processor that normally owns the shared address and data buses has let go of them. The host writes four byte registers:

- a low address byte;
- a control byte, holding three mid address bits, a drive enable, a read/write select and a chip-select bit;
- an upper address byte;
- a data byte.

From these registers the block drives the shared address bus (tri-stated), the SRAM upper address lines (always driven), the active-low memory read strobe, memory write strobe and chip select, and the shared data bus (tri-stated).

A load of one byte takes three steps. The host sets the address and data. It then sets drive, write and chip select together. It then clears chip select. A read-back works the same way with the write bit clear. The byte on the bus is captured into a readable register, and the value that remains is the one sampled on the edge at which chip select is released.

While the loader drives the address bus, it forces the bank-mapper multiplexer select high. This makes the upper SRAM address come from the upper address register. When the processor owns the bus, the data register also serves as the source of the processor's I/O read data.

Top module: `sram_image_loader`

## Requirements
- R1: After reset every register is zero. All three strobes are high, the upper address lines read 0, the captured byte reads 0, and neither shared bus is driven.
- R2: A host write with host_we=1 updates, on the next rising clock, the register chosen by host_sel: 0 = low address, 1 = control, 2 = upper address, 3 = data. In the control byte, bits [2:0] are address bits 10..8, bit 3 is drive enable, bit 4 is write (1) or read (0), and bit 5 is chip select.
- R3: When bus_released=1 and drive enable=1, cpu_addr carries {control[2:0], low address}. Otherwise cpu_addr is high impedance.
- R4: sram_a_hi always equals the upper address register, whatever the state of the bus.
- R5: banked_sel = banked_cmp OR (bus_released AND drive enable).
- R6: sram_cs_n is low exactly when bus_released, drive enable and the chip-select bit are all 1.
- R7: mem_wr_n is low exactly when sram_cs_n is low and the write bit is 1. mem_rd_n is low exactly when sram_cs_n is low and the write bit is 0. The two are never low together.
- R8: cpu_data carries the data register when mem_wr_n is low, or when cpu_iord=1 and bus_released=0. Otherwise cpu_data is high impedance.
- R9: With bus_released=0, both shared buses are undriven by the loader (except for R8's I/O read) and all three strobes stay high, whatever the register contents.
- R10: On each rising clock while mem_rd_n is low, rd_data takes the value on cpu_data. At all other times rd_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | host clock |
| rst_n | input | 1 | asynchronous active-low reset |
| host_we | input | 1 | host register write strobe |
| host_sel | input | 2 | register select for host writes |
| host_wdata | input | 8 | host write data |
| bus_released | input | 1 | processor has surrendered the shared bus |
| cpu_iord | input | 1 | processor I/O read of the data register |
| banked_cmp | input | 1 | bank-mapper comparator result |
| banked_sel | output | 1 | bank-mapper multiplexer select |
| cpu_addr | output | 11 | shared address bus, tri-stated |
| sram_a_hi | output | 8 | SRAM address bits 18..11 |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| mem_wr_n | output | 1 | memory write strobe, active low |
| mem_rd_n | output | 1 | memory read strobe, active low |
| cpu_data | inout | 8 | shared data bus, tri-stated |
| rd_data | output | 8 | captured read byte |

## Verification
The bench uses a known pattern driven weakly onto each shared bus to tell "undriven" apart from "driven". A design that leaks the address or data onto the bus while the processor still owns it would return a corrupted pattern. The bench sets the chip-select and write bits with drive enable clear, and then with the bus not released. A design that does not gate the strobes would write the SRAM there and corrupt later read-back, or show a low strobe.

Random bytes are written to random addresses and read back through the capture register. This exposes swapped address fields, a wrong strobe polarity, and a capture register that keeps sampling after chip select falls; the last shows up when the bus pattern changes after the read. The bank select is checked with the comparator both low and high.

// File: rtl/sram_ldr_pkg.sv
package sram_ldr_pkg;

  typedef enum logic [1:0] {
    SEL_LO  = 2'd0,
    SEL_CTL = 2'd1,
    SEL_HI  = 2'd2,
    SEL_DAT = 2'd3
  } ldr_sel_e;

  // control byte layout: mid address bits first, then three flags
  function automatic int drv_pos(input int mid_w);
    return mid_w;
  endfunction

  function automatic int rw_pos(input int mid_w);
    return mid_w + 1;
  endfunction

  function automatic int cs_pos(input int mid_w);
    return mid_w + 2;
  endfunction

endpackage

// File: rtl/loader_regs.sv
module loader_regs
  import sram_ldr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LO_W  = 8,
  parameter int MID_W = 3,
  parameter int HI_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [1:0]       host_sel,
  input  logic [DW-1:0]    host_wdata,
  output logic [LO_W-1:0]  lo_q,
  output logic [MID_W-1:0] mid_q,
  output logic             drv_q,
  output logic             rw_q,
  output logic             cs_q,
  output logic [HI_W-1:0]  hi_q,
  output logic [DW-1:0]    dat_q
);
  localparam int DRV_B = drv_pos(MID_W);
  localparam int RW_B  = rw_pos(MID_W);
  localparam int CS_B  = cs_pos(MID_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      mid_q <= '0;
      drv_q <= 1'b0;
      rw_q  <= 1'b0;
      cs_q  <= 1'b0;
      hi_q  <= '0;
      dat_q <= '0;
    end else if (host_we) begin
      unique case (ldr_sel_e'(host_sel))
        SEL_LO:  lo_q <= host_wdata[LO_W-1:0];
        SEL_CTL: begin
          mid_q <= host_wdata[MID_W-1:0];
          drv_q <= host_wdata[DRV_B];
          rw_q  <= host_wdata[RW_B];
          cs_q  <= host_wdata[CS_B];
        end
        SEL_HI:  hi_q  <= host_wdata[HI_W-1:0];
        SEL_DAT: dat_q <= host_wdata;
        default: ;
      endcase
    end
  end

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel == SEL_CTL) |=> (cs_q == $past(host_wdata[CS_B]) && drv_q == $past(host_wdata[DRV_B]))); // R2

endmodule

// File: rtl/loader_bus_ctl.sv
module loader_bus_ctl #(
  parameter int DW    = 8,
  parameter int LO_W  = 8,
  parameter int MID_W = 3,
  localparam int AW   = LO_W + MID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LO_W-1:0]  lo_q,
  input  logic [MID_W-1:0] mid_q,
  input  logic             drv_q,
  input  logic             rw_q,
  input  logic             cs_q,
  input  logic [DW-1:0]    dat_q,
  input  logic             bus_released,
  input  logic             cpu_iord,
  input  logic             banked_cmp,
  output logic             addr_oe,
  output logic [AW-1:0]    addr_val,
  output logic             data_oe,
  output logic [DW-1:0]    data_val,
  output logic             banked_sel,
  output logic             sram_cs_n,
  output logic             mem_wr_n,
  output logic             mem_rd_n,
  output logic             rd_on
);
  function automatic logic [AW-1:0] join_addr(input logic [MID_W-1:0] m,
                                               input logic [LO_W-1:0] l);
    return {m, l};
  endfunction

  logic load_owns;
  logic cs_on;
  logic wr_on;
  logic iord_on;

  always_comb begin
    load_owns = bus_released & drv_q;
    cs_on     = load_owns & cs_q;
    wr_on     = cs_on & rw_q;
    rd_on     = cs_on & ~rw_q;
    iord_on   = cpu_iord & ~bus_released;
  end

  assign addr_oe    = load_owns;
  assign addr_val   = join_addr(mid_q, lo_q);
  assign data_oe    = wr_on | iord_on;
  assign data_val   = dat_q;
  assign banked_sel = banked_cmp | load_owns;
  assign sram_cs_n  = ~cs_on;
  assign mem_wr_n   = ~wr_on;
  assign mem_rd_n   = ~rd_on;

  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_released |-> (sram_cs_n && mem_wr_n && mem_rd_n && !addr_oe)); // R9
  AST_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> !sram_cs_n); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_wr_n && !mem_rd_n)); // R7
  AST_CS_NEEDS_DRV: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_cs_n |-> addr_oe); // R6
  AST_BANK_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> banked_sel); // R5
  AST_DATA_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> data_oe); // R8

endmodule

// File: rtl/loader_capture.sv
module loader_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_on,
  input  logic [DW-1:0] bus_data,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_on) rd_data <= bus_data;
  end

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_on |=> $stable(rd_data)); // R10
  AST_CAPTURE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_on |=> (rd_data == $past(bus_data))); // R10

endmodule

// File: rtl/sram_image_loader.sv
module sram_image_loader #(
  parameter int DW    = 8,
  parameter int LO_W  = 8,
  parameter int MID_W = 3,
  parameter int HI_W  = 8,
  localparam int AW   = LO_W + MID_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [1:0]    host_sel,
  input  logic [DW-1:0] host_wdata,
  input  logic          bus_released,
  input  logic          cpu_iord,
  input  logic          banked_cmp,
  output logic          banked_sel,
  output logic [AW-1:0] cpu_addr,
  output logic [HI_W-1:0] sram_a_hi,
  output logic          sram_cs_n,
  output logic          mem_wr_n,
  output logic          mem_rd_n,
  inout  wire  [DW-1:0] cpu_data,
  output logic [DW-1:0] rd_data
);
  logic [LO_W-1:0]  lo_q;
  logic [MID_W-1:0] mid_q;
  logic             drv_q, rw_q, cs_q;
  logic [HI_W-1:0]  hi_q;
  logic [DW-1:0]    dat_q;
  logic             addr_oe, data_oe, rd_on;
  logic [AW-1:0]    addr_val;
  logic [DW-1:0]    data_val;

  loader_regs #(.DW(DW), .LO_W(LO_W), .MID_W(MID_W), .HI_W(HI_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .lo_q(lo_q), .mid_q(mid_q), .drv_q(drv_q),
    .rw_q(rw_q), .cs_q(cs_q), .hi_q(hi_q), .dat_q(dat_q)
  );

  loader_bus_ctl #(.DW(DW), .LO_W(LO_W), .MID_W(MID_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .lo_q(lo_q), .mid_q(mid_q), .drv_q(drv_q),
    .rw_q(rw_q), .cs_q(cs_q), .dat_q(dat_q), .bus_released(bus_released),
    .cpu_iord(cpu_iord), .banked_cmp(banked_cmp), .addr_oe(addr_oe),
    .addr_val(addr_val), .data_oe(data_oe), .data_val(data_val),
    .banked_sel(banked_sel), .sram_cs_n(sram_cs_n), .mem_wr_n(mem_wr_n),
    .mem_rd_n(mem_rd_n), .rd_on(rd_on)
  );

  loader_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .rd_on(rd_on), .bus_data(cpu_data),
    .rd_data(rd_data)
  );

  assign cpu_addr  = addr_oe ? addr_val : 'z;
  assign cpu_data  = data_oe ? data_val : 'z;
  assign sram_a_hi = hi_q;

endmodule

// File: tb/sram_image_loader_bench.sv
`timescale 1ns/100ps
module sram_image_loader_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic bus_released = 1'b0;
  logic cpu_iord = 1'b0;
  logic banked_cmp = 1'b0;
  logic banked_sel, sram_cs_n, mem_wr_n, mem_rd_n;
  logic [7:0] sram_a_hi, rd_data;
  wire  [10:0] cpu_addr;
  wire  [7:0]  cpu_data;
  logic aprobe = 1'b0, dprobe = 1'b0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sram_image_loader u_sram_image_loader (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .bus_released(bus_released), .cpu_iord(cpu_iord),
    .banked_cmp(banked_cmp), .banked_sel(banked_sel), .cpu_addr(cpu_addr),
    .sram_a_hi(sram_a_hi), .sram_cs_n(sram_cs_n), .mem_wr_n(mem_wr_n),
    .mem_rd_n(mem_rd_n), .cpu_data(cpu_data), .rd_data(rd_data)
  );

  // probe patterns show an undriven bus
  assign cpu_addr = aprobe ? 11'h2A5 : 'z;
  assign cpu_data = dprobe ? 8'hA5 : 'z;

  // SRAM model, 4096 bytes indexed by {a_hi[0], addr[10:0]}
  logic [7:0] mem [0:4095];
  logic [7:0] expm [0:4095];
  wire  [11:0] midx = {sram_a_hi[0], cpu_addr};
  wire  sram_oe = !mem_rd_n && !sram_cs_n;
  assign cpu_data = sram_oe ? mem[midx] : 'z;
  always @(negedge clk) if (!mem_wr_n && !sram_cs_n) mem[midx] <= cpu_data;

  function automatic logic [7:0] ctl_byte(input logic [2:0] m, input logic drv,
                                          input logic wr, input logic cs);
    return {2'b00, cs, wr, drv, m};
  endfunction

  function automatic logic [11:0] bidx(input logic [7:0] hi, input logic [2:0] m,
                                       input logic [7:0] lo);
    return {hi[0], m, lo};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk);
    host_we = 1'b1; host_sel = s; host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic strobes(input bit cs, input bit wr, input bit rd, input string tag);
    chk(sram_cs_n == cs, tag, sram_cs_n, cs);
    chk(mem_wr_n == wr, tag, mem_wr_n, wr);
    chk(mem_rd_n == rd, tag, mem_rd_n, rd);
  endtask

  task automatic load_byte(input logic [7:0] hi, input logic [2:0] m,
                           input logic [7:0] lo, input logic [7:0] d, input bit verify);
    hw(2'd0, lo);
    hw(2'd2, hi);
    hw(2'd3, d);
    hw(2'd1, ctl_byte(m, 1'b1, 1'b1, 1'b0));
    hw(2'd1, ctl_byte(m, 1'b1, 1'b1, 1'b1));
    if (verify) begin
      chk(cpu_addr == {m, lo}, "R3 address drive", cpu_addr, {m, lo});
      chk(sram_a_hi == hi, "R4 upper address", sram_a_hi, hi);
      chk(cpu_data == d, "R8 write data", cpu_data, d);
      strobes(1'b0, 1'b0, 1'b1, "R7 write strobes");
    end
    hw(2'd1, ctl_byte(m, 1'b1, 1'b1, 1'b0));
    expm[bidx(hi, m, lo)] = d;
  endtask

  task automatic read_byte(input logic [7:0] hi, input logic [2:0] m,
                           input logic [7:0] lo, input string tag);
    logic [7:0] e;
    e = expm[bidx(hi, m, lo)];
    hw(2'd0, lo);
    hw(2'd2, hi);
    hw(2'd1, ctl_byte(m, 1'b1, 1'b0, 1'b1));
    strobes(1'b0, 1'b1, 1'b0, "R7 read strobes");
    hw(2'd1, ctl_byte(m, 1'b1, 1'b0, 1'b0));
    chk(rd_data == e, tag, rd_data, e);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] vlo [0:23];
    logic [2:0] vm  [0:23];
    logic [7:0] vhi [0:23];
    void'($urandom(32'h1D2C3B4A));
    for (int i = 0; i < 4096; i++) begin mem[i] = 8'h00; expm[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_released = 1'b1;
    aprobe = 1'b1; dprobe = 1'b1;
    @(negedge clk);
    // R1 reset state
    strobes(1'b1, 1'b1, 1'b1, "R1 reset strobes");
    chk(sram_a_hi == 8'h00, "R1 reset upper", sram_a_hi, 0);
    chk(rd_data == 8'h00, "R1 reset capture", rd_data, 0);
    chk(cpu_addr == 11'h2A5, "R1 reset address undriven", cpu_addr, 11'h2A5);
    chk(cpu_data == 8'hA5, "R1 reset data undriven", cpu_data, 8'hA5);
    chk(banked_sel == 1'b0, "R5 reset bank select", banked_sel, 0);
    banked_cmp = 1'b1; #1;
    chk(banked_sel == 1'b1, "R5 comparator pass", banked_sel, 1);
    banked_cmp = 1'b0;

    // R2/R4 upper register follows host writes with drive off
    hw(2'd2, 8'hC3);
    chk(sram_a_hi == 8'hC3, "R4 upper while idle", sram_a_hi, 8'hC3);

    // R6: cs and write bits without drive enable do nothing
    hw(2'd3, 8'h5A);
    hw(2'd0, 8'h11);
    hw(2'd1, ctl_byte(3'd2, 1'b0, 1'b1, 1'b1));
    strobes(1'b1, 1'b1, 1'b1, "R6 no cs without drive");
    chk(cpu_addr == 11'h2A5, "R3 address undriven without drive", cpu_addr, 11'h2A5);
    chk(cpu_data == 8'hA5, "R8 data undriven without strobe", cpu_data, 8'hA5);

    // R9: bus held by processor, everything set
    bus_released = 1'b0;
    hw(2'd1, ctl_byte(3'd2, 1'b1, 1'b1, 1'b1));
    strobes(1'b1, 1'b1, 1'b1, "R9 held strobes");
    chk(cpu_addr == 11'h2A5, "R9 held address", cpu_addr, 11'h2A5);
    chk(cpu_data == 8'hA5, "R9 held data", cpu_data, 8'hA5);
    chk(banked_sel == 1'b0, "R5 no force while held", banked_sel, 0);
    // R8: processor I/O read uses data register
    dprobe = 1'b0; cpu_iord = 1'b1; #1;
    chk(cpu_data == 8'h5A, "R8 io read data", cpu_data, 8'h5A);
    cpu_iord = 1'b0; dprobe = 1'b1;
    hw(2'd1, 8'h00);
    bus_released = 1'b1;
    aprobe = 1'b0; dprobe = 1'b0;

    // R2: write with drive on, cs only set after; verify address then R5
    hw(2'd1, ctl_byte(3'd5, 1'b1, 1'b0, 1'b0));
    chk(cpu_addr == {3'd5, 8'h11}, "R3 address driven", cpu_addr, {3'd5, 8'h11});
    chk(banked_sel == 1'b1, "R5 forced by drive", banked_sel, 1);
    strobes(1'b1, 1'b1, 1'b1, "R6 no cs without bit");

    // directed corners: extreme addresses
    load_byte(8'hFF, 3'd7, 8'hFF, 8'h3C, 1'b1);
    load_byte(8'h00, 3'd0, 8'h00, 8'hC9, 1'b1);
    read_byte(8'hFF, 3'd7, 8'hFF, "R10 capture top address");
    read_byte(8'h00, 3'd0, 8'h00, "R10 capture zero address");

    // R10 hold: after cs release, bus pattern must not be captured
    dprobe = 1'b1;
    repeat (3) @(negedge clk);
    chk(rd_data == 8'hC9, "R10 hold after release", rd_data, 8'hC9);
    dprobe = 1'b0;

    // random loads and read-back
    for (int i = 0; i < 24; i++) begin
      vlo[i] = 8'($urandom);
      vm[i]  = 3'($urandom);
      vhi[i] = 8'($urandom);
      load_byte(vhi[i], vm[i], vlo[i], 8'($urandom), 1'b1);
    end
    for (int i = 0; i < 24; i++) read_byte(vhi[i], vm[i], vlo[i], "R10 random read-back");

    // R9 after loading: drop bus release mid-cycle
    hw(2'd1, ctl_byte(3'd1, 1'b1, 1'b1, 1'b1));
    bus_released = 1'b0; aprobe = 1'b1; #1;
    strobes(1'b1, 1'b1, 1'b1, "R9 release dropped");
    chk(cpu_addr == 11'h2A5, "R9 address freed", cpu_addr, 11'h2A5);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule